// File: doc/BRIEF.md
# SPI Display Register Access Engine

This block is an SPI master that performs register traffic for a small display controller. A client hands it one request at a time over a valid/ready handshake: write a 16-bit register, read a 16-bit register, or fetch the controller's status word. The engine turns the request into one or two chip-select-framed serial transfers and raises a one-cycle completion pulse. Reads and status fetches return their 16-bit result on a held output.

Every frame opens with a command byte. Its upper five bits are fixed at `01110`. The next bit is an identifier taken from `cfg_id`, then a select bit that chooses the index register or the data register, and last a direction bit. Register accesses are split in two: an index frame that names the register, then a data frame that moves the value. Chip select is released between the two frames. A status fetch is a single four-byte frame whose first returned byte after the command is a throwaway.

The serial clock is derived from the system clock by a half-period divider. The divider has a floor so that register traffic never exceeds the rate the controller accepts. An invert option complements every byte the engine sends.

Top module: `spidisp_reg_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: The first byte of every frame is `{5'b01110, id, sel, dir}`, where `sel` is 0 for the index register and 1 for the data register, and `dir` is 0 for write and 1 for read (bit 0). `id` is the value of `cfg_id` captured when the request is accepted.
- R3: `req_op` = 2'b00 (register write) sends two 24-bit frames. The first is the command byte with sel=0 and dir=0, then 0x00, then `req_addr`. The second is the command byte with sel=1 and dir=0, then `req_wdata[15:8]`, then `req_wdata[7:0]`.
- R4: `req_op` = 2'b01 (register read) sends the same index frame as R3, followed by a 24-bit frame made of the command byte with sel=1 and dir=1 and two 0x00 bytes. `rsp_rdata` is the second received byte (high half) followed by the third received byte (low half).
- R5: `req_op` = 2'b10 or 2'b11 (status read) sends one 32-bit frame made of the command byte with sel=0 and dir=1 and three 0x00 bytes. The second received byte is discarded, and `rsp_rdata` is the third received byte (high half) followed by the fourth (low half).
- R6: The serial protocol is SPI mode 0, most significant bit first. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is sampled on the rising edge. `spi_sck` stays low whenever `spi_cs_n` is high.
- R7: Each SCK high phase and each SCK low phase lasts exactly max(`cfg_half_div`, MIN_HALF) system clocks, where MIN_HALF = ceil(SYS_CLK_HZ / (2*MAX_SCK_HZ)). This is 7 with the defaults, which gives at most 4 MHz.
- R8: Between the two frames of one request, `spi_cs_n` stays high for at least two half-periods (one full SCK period).
- R9: With `cfg_invert` = 1, every transmitted byte, including the command and filler bytes, is bitwise complemented. Received data is not altered.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the cycle in which `rsp_done` pulses. `rsp_done` is high for exactly one cycle per request.
- R11: `rsp_rdata` changes only during a read or status request and holds its value otherwise, including through a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 2 | 00 write, 01 read, 10/11 status |
| req_addr | input | 8 | Register number for the index frame |
| req_wdata | input | 16 | Value for a register write |
| cfg_id | input | 1 | Identifier bit placed in each command byte |
| cfg_invert | input | 1 | Complement all transmitted bytes |
| cfg_half_div | input | DIV_W | Requested SCK half-period in system clocks |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Result of the last read or status request |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
The checker assumes that the configuration inputs and the request fields are held steady only at the accepting edge, because the engine captures them there. It also assumes that `spi_miso` is driven to a known level while chip select is low. The bench presents each request on one falling clock edge and withdraws it on the next. Its slave model changes `spi_miso` only on falling SCK edges and on chip-select assertion, so the value sampled on a rising edge was settled well before it. The bench never offers a new request until it has observed `rsp_done`.

// File: rtl/spidisp_pkg.sv
package spidisp_pkg;

   localparam int ADDR_W  = 8;
   localparam int DATA_W  = 16;
   localparam int FRAME_W = 32;
   localparam int NB_W    = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      OP_WRITE  = 2'b00,
      OP_READ   = 2'b01,
      OP_STATUS = 2'b10,
      OP_STAT2  = 2'b11
   } reg_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHIFT,
      ST_GAP
   } eng_state_e;

   // command byte: fixed prefix, identifier, register select, direction (LSB)
   function automatic logic [7:0] cmd_byte(input logic id, input logic sel, input logic dir);
      return {5'b01110, id, sel, dir};
   endfunction

   function automatic logic is_status(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/spidisp_half_tick.sv
module spidisp_half_tick #(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_cfg,
   output logic             tick
);

   logic [DIV_W-1:0] eff_half;
   logic [DIV_W-1:0] cnt;

   generate
      if (MIN_HALF > 1) begin : g_clamp
         assign eff_half = (half_cfg < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_cfg;
      end else begin : g_floor
         assign eff_half = (half_cfg == '0) ? DIV_W'(1) : half_cfg;
      end
   endgenerate

   assign tick = run && (cnt == eff_half - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + DIV_W'(1);
   end

endmodule

// File: rtl/spidisp_frame_builder.sv
module spidisp_frame_builder
   import spidisp_pkg::*;
(
   input  logic              data_phase,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              id,
   input  logic              invert,
   output logic [FRAME_W-1:0] word,
   output logic [NB_W-1:0]    nbits
);

   logic [FRAME_W-1:0] raw;

   always_comb begin
      if (!data_phase) begin
         if (is_status(op)) begin
            raw   = {cmd_byte(id, 1'b0, 1'b1), 24'h000000};
            nbits = NB_W'(32);
         end else begin
            raw   = {cmd_byte(id, 1'b0, 1'b0), 8'h00, addr, 8'h00};
            nbits = NB_W'(24);
         end
      end else if (op == OP_WRITE) begin
         raw   = {cmd_byte(id, 1'b1, 1'b0), wdata, 8'h00};
         nbits = NB_W'(24);
      end else begin
         raw   = {cmd_byte(id, 1'b1, 1'b1), 16'h0000, 8'h00};
         nbits = NB_W'(24);
      end
   end

   assign word = raw ^ {FRAME_W{invert}};

endmodule

// File: rtl/spidisp_frame_shifter.sv
module spidisp_frame_shifter
   import spidisp_pkg::*;
#(
   parameter int RX_W = DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic [NB_W-1:0]    n_bits,
   input  logic               tick,
   input  logic               miso,
   output logic               sck,
   output logic               cs_n,
   output logic               mosi,
   output logic               frame_end,
   output logic [RX_W-1:0]    rx_word
);

   logic [FRAME_W-1:0] tx_sr;
   logic [NB_W-1:0]    left;

   assign mosi      = !cs_n && tx_sr[FRAME_W-1];
   assign frame_end = !cs_n && tick && sck && (left == NB_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         tx_sr   <= '0;
         rx_word <= '0;
         left    <= '0;
      end else if (load) begin
         cs_n  <= 1'b0;
         sck   <= 1'b0;
         tx_sr <= tx_word;
         left  <= n_bits;
      end else if (!cs_n && tick) begin
         if (!sck) begin
            sck     <= 1'b1;
            rx_word <= {rx_word[RX_W-2:0], miso};
         end else begin
            sck   <= 1'b0;
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            if (left == NB_W'(1)) cs_n <= 1'b1;
            else                  left <= left - NB_W'(1);
         end
      end
   end

endmodule

// File: rtl/spidisp_reg_engine.sv
module spidisp_reg_engine
   import spidisp_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int MAX_SCK_HZ = 4_000_000,
   parameter int DIV_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cfg_id,
   input  logic              cfg_invert,
   input  logic [DIV_W-1:0]  cfg_half_div,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int MIN_HALF = (SYS_CLK_HZ + 2 * MAX_SCK_HZ - 1) / (2 * MAX_SCK_HZ);

   generate
      if (MAX_SCK_HZ <= 0 || SYS_CLK_HZ <= 0) begin : g_bad_rate
         $error("clock rates must be positive");
      end
      if (DIV_W < 2 || MIN_HALF >= (1 << DIV_W)) begin : g_bad_div
         $error("DIV_W too narrow for the minimum half period");
      end
   endgenerate

   eng_state_e         state;
   logic               data_phase;
   logic               gap_second;
   logic [1:0]         op_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic               id_q;
   logic               inv_q;
   logic [DIV_W-1:0]   half_q;
   logic               done_q;
   logic [DATA_W-1:0]  rdata_q;

   logic               tick;
   logic               frame_end;
   logic [FRAME_W-1:0] fr_word;
   logic [NB_W-1:0]    fr_bits;
   logic [DATA_W-1:0]  rx_word;
   logic               run;
   logic               two_frames;

   assign run        = (state == ST_SHIFT) || (state == ST_GAP);
   assign two_frames = !is_status(op_q);

   spidisp_half_tick #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half_cfg (half_q),
      .tick     (tick)
   );

   spidisp_frame_builder u_build (
      .data_phase (data_phase),
      .op         (op_q),
      .addr       (addr_q),
      .wdata      (wdata_q),
      .id         (id_q),
      .invert     (inv_q),
      .word       (fr_word),
      .nbits      (fr_bits)
   );

   spidisp_frame_shifter #(.RX_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (state == ST_LOAD),
      .tx_word   (fr_word),
      .n_bits    (fr_bits),
      .tick      (tick),
      .miso      (spi_miso),
      .sck       (spi_sck),
      .cs_n      (spi_cs_n),
      .mosi      (spi_mosi),
      .frame_end (frame_end),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         data_phase <= 1'b0;
         gap_second <= 1'b0;
         op_q       <= OP_WRITE;
         addr_q     <= '0;
         wdata_q    <= '0;
         id_q       <= 1'b1;
         inv_q      <= 1'b0;
         half_q     <= '0;
         done_q     <= 1'b0;
         rdata_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               op_q       <= req_op;
               addr_q     <= req_addr;
               wdata_q    <= req_wdata;
               id_q       <= cfg_id;
               inv_q      <= cfg_invert;
               half_q     <= cfg_half_div;
               data_phase <= 1'b0;
               state      <= ST_LOAD;
            end
            ST_LOAD: state <= ST_SHIFT;
            ST_SHIFT: if (frame_end) begin
               // result bytes are the last two received in a read or status frame
               if (is_status(op_q) || (data_phase && op_q == OP_READ))
                  rdata_q <= rx_word;
               gap_second <= 1'b0;
               state      <= ST_GAP;
            end
            ST_GAP: if (tick) begin
               if (!gap_second) begin
                  gap_second <= 1'b1;
               end else if (two_frames && !data_phase) begin
                  data_phase <= 1'b1;
                  state      <= ST_LOAD;
               end else begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;

endmodule

// File: rtl/spidisp_reg_engine_chk.sv
module spidisp_reg_engine_chk #(
   parameter int MIN_HALF = 7
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_ready,
   input logic        rsp_done,
   input logic [15:0] rsp_rdata,
   input logic        spi_sck,
   input logic        spi_cs_n,
   input logic        spi_mosi
);

   logic        prev_sck;
   logic        prev_cs;
   logic        seen_frame;
   logic [15:0] since_edge;
   logic [15:0] cs_high;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sck   <= 1'b0;
         prev_cs    <= 1'b1;
         seen_frame <= 1'b0;
         since_edge <= '0;
         cs_high    <= '0;
      end else begin
         prev_sck <= spi_sck;
         prev_cs  <= spi_cs_n;
         if (spi_sck != prev_sck)        since_edge <= 16'd1;
         else if (since_edge != 16'hFFFF) since_edge <= since_edge + 16'd1;
         if (spi_cs_n && !prev_cs)        cs_high <= 16'd1;
         else if (!spi_cs_n)              cs_high <= '0;
         else if (cs_high != 16'hFFFF)    cs_high <= cs_high + 16'd1;
         if (rsp_done)                    seen_frame <= 1'b0;
         else if (spi_cs_n && !prev_cs)   seen_frame <= 1'b1;
      end
   end

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (spi_cs_n && !spi_sck));

   a_r6_no_sck_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   a_r6_mosi_held_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && !spi_cs_n) |-> $stable(spi_mosi));

   a_r7_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck != prev_sck) |-> (since_edge >= 16'(MIN_HALF)));

   a_r8_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && prev_cs && seen_frame) |-> (cs_high >= 16'(2 * MIN_HALF)));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   a_r10_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && $past(req_ready)) |-> $stable(rsp_rdata));

endmodule

bind spidisp_reg_engine spidisp_reg_engine_chk #(.MIN_HALF(MIN_HALF)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .rsp_rdata (rsp_rdata),
   .spi_sck   (spi_sck),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi)
);

// File: tb/tb_spidisp_reg_engine.sv
module tb_spidisp_reg_engine;

   localparam int SYS_HZ   = 50_000_000;
   localparam int SCK_MAX  = 4_000_000;
   localparam int MIN_H    = (SYS_HZ + 2 * SCK_MAX - 1) / (2 * SCK_MAX);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'b00;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        cfg_id = 1'b1;
   logic        cfg_invert = 1'b0;
   logic [7:0]  cfg_half_div = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   always #10 clk = ~clk;

   spidisp_reg_engine #(.SYS_CLK_HZ(SYS_HZ), .MAX_SCK_HZ(SCK_MAX), .DIV_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_id(cfg_id), .cfg_invert(cfg_invert), .cfg_half_div(cfg_half_div),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   typedef struct {
      int          n;
      logic [31:0] bits;
      string       tag;
   } frame_t;

   frame_t      exp_frames[$];
   logic [31:0] resp_q[$];
   int          checks = 0;
   int          errors = 0;
   bit          mon_on = 1'b0;
   logic [15:0] last_rd = 16'h0000;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] cmd(input bit id, input bit sel, input bit dir);
      return {5'b01110, id, sel, dir};
   endfunction

   // slave model and frame monitor (scoreboard consumer)
   bit          frame_open = 1'b0;
   logic [31:0] cur_resp;
   logic [31:0] got_bits;
   int          got_n;

   always @(negedge spi_cs_n or posedge spi_cs_n or posedge spi_sck or negedge spi_sck) begin
      if (mon_on) begin
         if (spi_cs_n) begin
            if (frame_open) begin
               frame_open = 1'b0;
               if (exp_frames.size() == 0) begin
                  check(1'b0, "R3 unexpected frame", got_bits, 32'h0);
               end else begin
                  frame_t e;
                  e = exp_frames.pop_front();
                  check(got_n == e.n, {e.tag, " frame length"}, got_n, e.n);
                  check(got_bits == e.bits, {e.tag, " frame bits"}, got_bits, e.bits);
               end
            end
         end else if (!frame_open) begin
            frame_open = 1'b1;
            cur_resp   = (resp_q.size() != 0) ? resp_q.pop_front() : 32'h0;
            got_bits   = '0;
            got_n      = 0;
            spi_miso   = cur_resp[31];
            cur_resp   = cur_resp << 1;
         end else if (spi_sck) begin
            got_bits = {got_bits[30:0], spi_mosi};
            got_n++;
         end else begin
            spi_miso = cur_resp[31];
            cur_resp = cur_resp << 1;
         end
      end
   end

   // driver: pushes expected frames and result, then observes the request to completion
   task automatic do_req(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] wd,
                         input bit id, input bit inv, input logic [7:0] half, input logic [15:0] rd_val);
      int          eh;
      int          nfr;
      logic [31:0] m24;
      frame_t      f;
      int          cyc, hi_run, hi_min, hi_max, cs_run, gap_min, rises, viol;
      logic        p_sck, p_mosi, p_cs;
      eh  = (int'(half) < MIN_H) ? MIN_H : int'(half);
      m24 = inv ? 32'h00FF_FFFF : 32'h0;
      if (op[1]) begin
         f.n = 32; f.bits = {cmd(id, 0, 1), 24'h0} ^ (inv ? 32'hFFFF_FFFF : 32'h0); f.tag = "R5 status";
         exp_frames.push_back(f);
         resp_q.push_back({8'hC3, 8'h5A, rd_val});
         last_rd = rd_val;
         nfr = 1;
      end else begin
         f.n = 24; f.bits = {8'h00, cmd(id, 0, 0), 8'h00, addr} ^ m24; f.tag = "R2 index";
         exp_frames.push_back(f);
         resp_q.push_back(32'hFFFF_FFFF);
         if (op == 2'b00) begin
            f.bits = {8'h00, cmd(id, 1, 0), wd} ^ m24; f.tag = "R3 write data";
            resp_q.push_back({8'hC3, 16'hA5A5, 8'h00});
         end else begin
            f.bits = {8'h00, cmd(id, 1, 1), 16'h0} ^ m24; f.tag = "R4 read data";
            resp_q.push_back({8'hC3, rd_val, 8'h00});
            last_rd = rd_val;
         end
         exp_frames.push_back(f);
         nfr = 2;
      end
      @(negedge clk);
      req_op = op; req_addr = addr; req_wdata = wd;
      cfg_id = id; cfg_invert = inv; cfg_half_div = half;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
      cyc = 0; hi_run = 0; hi_min = 100000; hi_max = 0; cs_run = 0; gap_min = 100000;
      rises = 0; viol = 0; p_sck = 1'b0; p_mosi = spi_mosi; p_cs = 1'b1;
      while (!rsp_done && cyc < 40000) begin
         if (spi_sck) hi_run++;
         else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
         end
         if (spi_cs_n) begin
            if (!p_cs) begin rises++; cs_run = 1; end
            else cs_run++;
         end else if (p_cs && rises > 0 && cs_run < gap_min) gap_min = cs_run;
         if (spi_sck && p_sck && spi_mosi !== p_mosi) viol++;
         if (spi_sck && spi_cs_n) viol++;
         p_sck = spi_sck; p_mosi = spi_mosi; p_cs = spi_cs_n;
         @(negedge clk);
         cyc++;
      end
      check(rsp_done == 1'b1, "R10 done reached", rsp_done, 1);
      check(req_ready == 1'b1, "R10 ready with done", req_ready, 1);
      check(rsp_rdata == last_rd, op == 2'b00 ? "R11 rdata held" : (op[1] ? "R5 status value" : "R4 read value"),
            rsp_rdata, last_rd);
      check(hi_min == eh && hi_max == eh, "R7 half period", hi_max, eh);
      check(viol == 0, "R6 mode 0 timing", viol, 0);
      check(rises == nfr, "R3 frame count", rises, nfr);
      if (nfr == 2) check(gap_min >= 2 * eh, "R8 inter-frame gap", gap_min, 2 * eh);
      check(exp_frames.size() == 0, "R2 scoreboard drained", exp_frames.size(), 0);
      @(negedge clk);
      check(rsp_done == 1'b0, "R10 done single cycle", rsp_done, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      check(spi_cs_n == 1'b1, "R1 cs idle high", spi_cs_n, 1);
      check(spi_sck == 1'b0, "R1 sck idle low", spi_sck, 0);
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      check(rsp_done == 1'b0, "R1 done low after reset", rsp_done, 0);
      check(rsp_rdata == 16'h0, "R1 rdata reset", rsp_rdata, 0);
      do_req(2'b00, 8'h12, 16'hBEEF, 1'b1, 1'b0, 8'd0,  16'h0000); // R3, R7 clamp
      do_req(2'b01, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd3,  16'h9221); // R4
      do_req(2'b10, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd7,  16'h1234); // R5
      do_req(2'b00, 8'h10, 16'h4240, 1'b1, 1'b1, 8'd0,  16'h0000); // R9 write
      do_req(2'b01, 8'h45, 16'h0000, 1'b0, 1'b1, 8'd10, 16'hDB00); // R9 read, R7 above floor
      do_req(2'b00, 8'h03, 16'h1030, 1'b0, 1'b0, 8'd9,  16'h0000); // R11 hold
      do_req(2'b11, 8'h00, 16'h0000, 1'b0, 1'b1, 8'd8,  16'h8001); // R5 alt code, R9
      check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 idle after traffic", {spi_cs_n, spi_sck}, 2'b10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule